// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDR SDRAM command bus from reset until the memory is ready for ordinary traffic. After reset it holds the bus in the deselected (inhibit) state and waits for a clock-stable indication. It then drives NOP for a start-up interval sized from a clock-frequency parameter and a microsecond parameter. After that it issues one all-bank precharge, two auto-refresh commands and one mode-register load. Each command is separated from the next by NOP cycles that cover the relevant device timing.

The mode-register value is built at elaboration from parameter fields: burst length code, burst type, CAS latency, operating mode and write-burst mode. Once the settle time after the load has run out, `init_done` rises. From then on the sequencer only drives NOP, so an access controller can take over the bus.

The state machine walks these states in order: `ST_AWAIT_CLK` (inhibit, left when `clk_stable` is sampled high), `ST_HOLD` (NOP for the start-up interval), `ST_PRECHARGE`, `ST_WAIT_RP`, `ST_REFRESH_A`, `ST_WAIT_RC_A`, `ST_REFRESH_B`, `ST_WAIT_RC_B`, `ST_LOAD_MODE`, `ST_WAIT_MRD` and `ST_READY`, which it holds until reset. Each command state lasts one cycle. Each wait state is left when its down-counter expires. All bus pins and `init_done` are registered, so the bus shows a state one cycle after the state register holds it.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after reset until `clk_stable` has been sampled high, the bus drives INHIBIT. INHIBIT is {cs_n,ras_n,cas_n,we_n} = 1111, with `addr` = 0, `ba` = 0 and `init_done` = 0.
- R2: Once `clk_stable` has been sampled high, exactly STARTUP_US*CLK_MHZ cycles of NOP ({cs_n,ras_n,cas_n,we_n} = 0111) appear before the first other command.
- R3: Changes of `clk_stable` after it has first been sampled high have no effect on the commands or their timing.
- R4: The first command after the start-up NOPs is PRECHARGE (0010). It drives only `addr` bit 10 high and `ba` = 0, which selects all banks.
- R5: Exactly T_RP-1 NOP cycles separate the precharge from the first AUTO REFRESH (0001).
- R6: Exactly two AUTO REFRESH commands are issued. Each is followed by exactly T_RC-1 NOP cycles before the next command.
- R7: After the second refresh gap, LOAD MODE (0000) is issued with `ba` = 0 and `addr` equal to the mode word, zero-extended to ADDR_W.
- R8: The mode word carries the burst length code in bits 2:0, the burst type in bit 3, the CAS latency in bits 6:4, the operating mode in bits 8:7 and the write-burst mode in bit 9. All higher bits are zero.
- R9: `init_done` rises after exactly T_MRD-1 NOP cycles following LOAD MODE. It stays high until reset, and the bus drives NOP for as long as it is high.
- R10: No command other than precharge, refresh, refresh, load (in that order) is issued. Each is followed by at least one NOP, and none follows the load.
- R11: Asserting reset at any point restarts the whole sequence from the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_stable | input | 1 | High when the memory clock is within specification |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (all-bank flag or mode word) |
| ba | output | BA_W | Bank address, always zero during this sequence |
| init_done | output | 1 | Sequence complete; bus handed over |

## Verification
A state register that skips, repeats or stalls shows up on the command pins one cycle after the faulty transition. The symptom is a missing or extra refresh, a command out of order, or a NOP gap of the wrong length. A miscounted wait shows as a gap one or more cycles off the computed length. That difference appears as soon as the following command or the `init_done` edge arrives. A wrongly packed mode word or a wrong precharge address is visible on `addr` in the single cycle that carries that command.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

    // Command pin pattern {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        BUS_INHIBIT   = 4'b1111,
        BUS_NOP       = 4'b0111,
        BUS_PRECHARGE = 4'b0010,
        BUS_REFRESH   = 4'b0001,
        BUS_LOAD_MODE = 4'b0000
    } bus_cmd_e;

    typedef enum logic [3:0] {
        ST_AWAIT_CLK,
        ST_HOLD,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH_A,
        ST_WAIT_RC_A,
        ST_REFRESH_B,
        ST_WAIT_RC_B,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_READY
    } seq_state_e;

    localparam int ALL_BANK_BIT = 10;
    localparam int MODE_BITS    = 12;

    // Field positions are decoded by the memory device
    function automatic logic [MODE_BITS-1:0] pack_mode(
        input logic [2:0] burst_len,
        input logic       burst_type,
        input logic [2:0] cas_lat,
        input logic [1:0] op_mode,
        input logic       wr_burst
    );
        return {2'b00, wr_burst, op_mode, cas_lat, burst_type, burst_len};
    endfunction

endpackage

// File: rtl/pwrup_timer.sv
module pwrup_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
    import sdram_pwrup_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int HOLD_CYC = 13300,
    parameter int T_RP     = 3,
    parameter int T_RC     = 9,
    parameter int T_MRD    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_stable,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output bus_cmd_e         cmd,
    output logic             ready
);

    // A wait state lasting N cycles is loaded with N-1
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] RC_LOAD   = CNT_W'(T_RC - 2);
    localparam logic [CNT_W-1:0] MRD_LOAD  = CNT_W'(T_MRD - 2);

    seq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_AWAIT_CLK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_AWAIT_CLK: begin
                if (clk_stable) begin
                    state_d  = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LOAD;
                end
            end
            ST_HOLD: begin
                if (expired) state_d = ST_PRECHARGE;
            end
            ST_PRECHARGE: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = RP_LOAD;
            end
            ST_WAIT_RP: begin
                if (expired) state_d = ST_REFRESH_A;
            end
            ST_REFRESH_A: begin
                state_d  = ST_WAIT_RC_A;
                tmr_load = 1'b1;
                tmr_val  = RC_LOAD;
            end
            ST_WAIT_RC_A: begin
                if (expired) state_d = ST_REFRESH_B;
            end
            ST_REFRESH_B: begin
                state_d  = ST_WAIT_RC_B;
                tmr_load = 1'b1;
                tmr_val  = RC_LOAD;
            end
            ST_WAIT_RC_B: begin
                if (expired) state_d = ST_LOAD_MODE;
            end
            ST_LOAD_MODE: begin
                state_d  = ST_WAIT_MRD;
                tmr_load = 1'b1;
                tmr_val  = MRD_LOAD;
            end
            ST_WAIT_MRD: begin
                if (expired) state_d = ST_READY;
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_AWAIT_CLK;
            end
        endcase
    end

    always_comb begin
        ready = 1'b0;
        unique case (state_q)
            ST_AWAIT_CLK: cmd = BUS_INHIBIT;
            ST_PRECHARGE: cmd = BUS_PRECHARGE;
            ST_REFRESH_A: cmd = BUS_REFRESH;
            ST_REFRESH_B: cmd = BUS_REFRESH;
            ST_LOAD_MODE: cmd = BUS_LOAD_MODE;
            ST_READY: begin
                cmd   = BUS_NOP;
                ready = 1'b1;
            end
            default: cmd = BUS_NOP;
        endcase
    end

endmodule

// File: rtl/pwrup_bus_drive.sv
module pwrup_bus_drive
    import sdram_pwrup_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter logic [ADDR_W-1:0] MODE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_cmd_e          cmd_i,
    input  logic              ready_i,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam logic [ADDR_W-1:0] ALL_BANK_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

    logic [3:0]        pins_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic              done_q;

    always_comb begin
        unique case (cmd_i)
            BUS_PRECHARGE: addr_d = ALL_BANK_ADDR;
            BUS_LOAD_MODE: addr_d = MODE_ADDR;
            default:       addr_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= BUS_INHIBIT;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            pins_q <= cmd_i;
            addr_q <= addr_d;
            done_q <= ready_i;
        end
    end

    assign {cs_n, ras_n, cas_n, we_n} = pins_q;
    assign addr      = addr_q;
    assign ba        = '0;
    assign init_done = done_q;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_pwrup_pkg::*;
#(
    parameter int         CLK_MHZ          = 133,
    parameter int         STARTUP_US       = 100,
    parameter int         T_RP             = 3,
    parameter int         T_RC             = 9,
    parameter int         T_MRD            = 2,
    parameter int         ADDR_W           = 12,
    parameter int         BA_W             = 2,
    parameter logic [2:0] BURST_LEN_CODE   = 3'b011,
    parameter logic       BURST_INTERLEAVE = 1'b0,
    parameter logic [2:0] CAS_LATENCY      = 3'd3,
    parameter logic [1:0] OP_MODE          = 2'b00,
    parameter logic       WRITE_SINGLE     = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_stable,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int HOLD_CYC = STARTUP_US * CLK_MHZ;
    localparam int GAP_MAX  = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int MAX_CYC  = (HOLD_CYC > GAP_MAX) ? HOLD_CYC : GAP_MAX;
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [MODE_BITS-1:0] MODE_WORD =
        pack_mode(BURST_LEN_CODE, BURST_INTERLEAVE, CAS_LATENCY, OP_MODE, WRITE_SINGLE);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_WORD);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    bus_cmd_e         seq_cmd;
    logic             seq_ready;

    pwrup_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwrup_fsm #(
        .CNT_W    (CNT_W),
        .HOLD_CYC (HOLD_CYC),
        .T_RP     (T_RP),
        .T_RC     (T_RC),
        .T_MRD    (T_MRD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .expired    (tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .cmd        (seq_cmd),
        .ready      (seq_ready)
    );

    pwrup_bus_drive #(
        .ADDR_W    (ADDR_W),
        .BA_W      (BA_W),
        .MODE_ADDR (MODE_ADDR)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (seq_cmd),
        .ready_i   (seq_ready),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .addr      (addr),
        .ba        (ba),
        .init_done (init_done)
    );

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk
    import sdram_pwrup_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                BA_W      = 2,
    parameter logic [ADDR_W-1:0] MODE_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_stable,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);

    localparam logic [ADDR_W-1:0] ALL_BANK_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

    logic [3:0] pins;
    logic       seen_stable_q;
    logic [1:0] refresh_cnt_q;

    assign pins = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_stable_q <= 1'b0;
            refresh_cnt_q <= '0;
        end else begin
            if (clk_stable) seen_stable_q <= 1'b1;
            if (pins == BUS_REFRESH && refresh_cnt_q != 2'd3)
                refresh_cnt_q <= refresh_cnt_q + 2'd1;
        end
    end

    a_r1_inhibit_until_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_stable_q |-> (pins == BUS_INHIBIT && !init_done));

    a_r4_precharge_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == BUS_PRECHARGE) |-> (addr == ALL_BANK_ADDR && ba == '0));

    a_r6_refresh_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == BUS_REFRESH) |-> (refresh_cnt_q < 2'd2));

    a_r6_two_refreshes_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == BUS_LOAD_MODE) |-> (refresh_cnt_q == 2'd2));

    a_r7_mode_word_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == BUS_LOAD_MODE) |-> (addr == MODE_ADDR && ba == '0));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r9_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == BUS_NOP));

    a_r10_nop_after_command: assert property (@(posedge clk) disable iff (!rst_n)
        (pins inside {BUS_PRECHARGE, BUS_REFRESH, BUS_LOAD_MODE}) |=> (pins == BUS_NOP));

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .MODE_ADDR (MODE_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_stable (clk_stable),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .addr       (addr),
    .ba         (ba),
    .init_done  (init_done)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

    localparam int CLK_MHZ    = 20;
    localparam int STARTUP_US = 5;
    localparam int T_RP       = 3;
    localparam int T_RC       = 7;
    localparam int T_MRD      = 4;
    localparam int HOLD       = CLK_MHZ * STARTUP_US;

    localparam logic [2:0] BL = 3'b010;
    localparam logic       BI = 1'b1;
    localparam logic [2:0] CL = 3'd2;
    localparam logic [1:0] OM = 2'b00;
    localparam logic       WS = 1'b1;

    localparam logic [3:0] P_INH = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_LMR = 4'b0000;
    localparam logic [3:0] P_DONE_MARK = 4'b1010;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        clk_stable;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba;
    logic        init_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic [3:0]  pins;
        logic [11:0] addr;
        int          gap;
        string       gap_req;
        string       field_req;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ          (CLK_MHZ),
        .STARTUP_US       (STARTUP_US),
        .T_RP             (T_RP),
        .T_RC             (T_RC),
        .T_MRD            (T_MRD),
        .ADDR_W           (12),
        .BA_W             (2),
        .BURST_LEN_CODE   (BL),
        .BURST_INTERLEAVE (BI),
        .CAS_LATENCY      (CL),
        .OP_MODE          (OM),
        .WRITE_SINGLE     (WS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_stable (clk_stable),
        .cs_n       (cs_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .addr       (addr),
        .ba         (ba),
        .init_done  (init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] p, input logic [11:0] a, input int g,
                        input string greq, input string freq);
        exp_item_t it;
        it.pins = p; it.addr = a; it.gap = g; it.gap_req = greq; it.field_req = freq;
        exp_q.push_back(it);
    endtask

    // R8: layout computed from field positions
    function automatic logic [11:0] expected_mode();
        return 12'(int'(WS) * 512 + int'(OM) * 128 + int'(CL) * 16 + int'(BI) * 8 + int'(BL));
    endfunction

    task automatic push_sequence();
        push(P_PRE, 12'h400, HOLD, "R2", "R4");
        push(P_REF, 12'h000, T_RP - 1, "R5", "R10");
        push(P_REF, 12'h000, T_RC - 1, "R6", "R10");
        push(P_LMR, expected_mode(), T_RC - 1, "R6", "R7_R8");
        push(P_DONE_MARK, 12'h000, T_MRD - 1, "R9", "R9");
    endtask

    task automatic check_reset_state(input string req);
        check({cs_n, ras_n, cas_n, we_n} == P_INH, req, {cs_n, ras_n, cas_n, we_n}, P_INH);
        check(addr == 12'h000 && ba == 2'b00, req, {ba, addr}, 0);
        check(init_done == 1'b0, req, init_done, 0);
    endtask

    // Monitor: scoreboard compare
    initial begin
        int  nop_run;
        bit  done_seen;
        logic [3:0] p;
        exp_item_t it;
        nop_run = 0;
        done_seen = 0;
        forever begin
            @(posedge clk);
            #1;
            if (!rst_n) begin
                nop_run = 0;
                done_seen = 0;
            end else begin
                p = {cs_n, ras_n, cas_n, we_n};
                if (init_done && !done_seen) begin
                    done_seen = 1;
                    if (exp_q.size() == 0) begin
                        check(0, "R9", 1, 0);
                    end else begin
                        it = exp_q.pop_front();
                        check(it.pins == P_DONE_MARK, "R9", it.pins, P_DONE_MARK);
                        check(nop_run == it.gap, it.gap_req, nop_run, it.gap);
                    end
                end
                if (p == P_NOP) begin
                    nop_run++;
                end else if (p != P_INH) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R10", p, P_NOP);
                    end else begin
                        it = exp_q.pop_front();
                        check(p == it.pins, "R10", p, it.pins);
                        check(addr == it.addr && ba == 2'b00, it.field_req, addr, it.addr);
                        check(nop_run == it.gap, it.gap_req, nop_run, it.gap);
                    end
                    nop_run = 0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_done();
        int guard = 0;
        while (!init_done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check(init_done == 1'b1, "R9", init_done, 1);
    endtask

    // Driver
    initial begin
        rst_n = 1'b0;
        clk_stable = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("R1");

        // Run 1: clock not stable for a while, then dropped during hold (R3)
        push_sequence();
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check({cs_n, ras_n, cas_n, we_n} == P_INH && !init_done, "R1",
                  {cs_n, ras_n, cas_n, we_n}, P_INH);
        end
        clk_stable = 1'b1;
        repeat (30) @(negedge clk);
        clk_stable = 1'b0;       // R3: must be ignored
        repeat (5) @(negedge clk);
        clk_stable = 1'b1;
        repeat (3) @(negedge clk);
        clk_stable = 1'b0;
        wait_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(init_done && {cs_n, ras_n, cas_n, we_n} == P_NOP, "R9",
                  {init_done, cs_n, ras_n, cas_n, we_n}, {1'b1, P_NOP});
        end
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);

        // Run 2: reset mid-sequence with clock already stable (R11)
        clk_stable = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R11");
        exp_q.delete();
        push_sequence();
        rst_n = 1'b1;
        repeat (HOLD + 6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R11");
        exp_q.delete();
        push_sequence();
        rst_n = 1'b1;
        wait_done();
        repeat (10) @(negedge clk);
        check(init_done == 1'b1, "R9", init_done, 1);
        check(exp_q.size() == 0, "R11", exp_q.size(), 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule